// File: doc/BRIEF.md
# Event Counter and Watchdog with One Shared Prescaler

This block holds an 8-bit event counter and a watchdog. Both sit behind one binary prescaler, and only one of them can own it at a time. A mode word written through a single strobe sets four things: what the counter counts (every clock cycle, or edges on an external pin that is already synchronised), which pin edge counts, which side owns the prescaler, and a 3-bit ratio code. The ratio code is read differently for each owner. Given to the counter, code k divides by 2^(k+1), from 1:2 up to 1:256. Given to the watchdog, code k divides by 2^k, from 1:1 up to 1:128, and code 0 bypasses the prescaler.

The counter can be read at any time and written through its own strobe. When it wraps from its largest value to zero it raises a one-cycle overflow pulse. The watchdog counts ticks from a slow external timebase. Each run of 2^WDT_BASE_W ticks makes one base period, and the base periods pass through the prescaler when the watchdog owns it. At the end of the chain the watchdog emits a one-cycle time-out pulse, which the surrounding logic uses as a reset request. A clear strobe, raised by the clear-watchdog and sleep operations, restarts the watchdog. A static enable input holds the watchdog off entirely.

Top module: `tmr_wdog_unit`

## Requirements
- R1: After reset the counter reads 0, both pulse outputs are low, and the mode is pin source, falling edge, prescaler owned by the watchdog, ratio code 7. The counter therefore stays at 0 while the pin is held low.
- R2: A counter write puts the written value on `cnt_rdata` from the next cycle. It takes precedence over an increment in the same cycle. Without a write, the counter changes by at most +1 per cycle.
- R3: With mode bit 5 = 0 (internal source) and mode bit 3 = 1 (prescaler owned by the watchdog), the counter increments on every clock.
- R4: With mode bit 3 = 0 the counter increments once per 2^(k+1) source events, where k = mode bits 2..0. This holds for both the clock source and the pin source.
- R5: While the counter owns the prescaler, a counter write clears the prescaler count.
- R6: With mode bit 5 = 1 the counter source is edges on `ext_pin`. Mode bit 4 = 0 selects rising edges and 1 selects falling edges. The other edge has no effect on the count.
- R7: An increment from the all-ones value gives 0, and `cnt_ovf` is high for exactly the one cycle in which the counter reads 0.
- R8: One watchdog base period is 2^WDT_BASE_W ticks of `wdt_tick` (16 by default). When the counter owns the prescaler, or when the watchdog owns it with k = 0, every base period produces one `wdt_timeout` pulse. The pulse lasts one cycle and appears in the cycle after the clock edge that takes the completing tick.
- R9: With mode bit 3 = 1, a time-out needs 2^k base periods, where k = mode bits 2..0.
- R10: `wdt_clr` zeroes the base count and, when the watchdog owns it, the prescaler. It takes precedence over a tick in the same cycle. No time-out follows a clear cycle.
- R11: While `wdt_en` is low, ticks are ignored, the base count is held at zero and no time-out is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one instruction cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Mode word write strobe |
| mode_wdata | input | 6 | Mode word: [2:0] ratio code, [3] prescaler owner (1 = watchdog), [4] edge (1 = falling), [5] source (1 = pin) |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter write data |
| cnt_rdata | output | 8 | Current counter value |
| cnt_ovf | output | 1 | One-cycle pulse on wrap to zero |
| ext_pin | input | 1 | Synchronised external count pin |
| wdt_tick | input | 1 | One-cycle watchdog timebase tick |
| wdt_clr | input | 1 | Watchdog clear strobe (clear-watchdog or sleep) |
| wdt_en | input | 1 | Static watchdog enable from configuration |
| wdt_timeout | output | 1 | One-cycle watchdog time-out (reset request) |

## Verification
A prescaler left stale after a counter write, or a prescaler count that moves for the wrong owner, shows up at the first increment after the write: that increment lands one or more source events early. A wrong tap choice makes the counter or the time-out arrive a factor of two early or late, so the checks sample one cycle, or one tick, before and after each expected step. A watchdog clear that fails to reach the base count or the prescaler makes a time-out appear tick periods early, and the bench counts those pulses against exact tick totals. A wrong overflow or wrap decode is visible on the very cycle the counter passes through zero.

// File: rtl/tmr_wdog_pkg.sv
package tmr_wdog_pkg;

   // counter source selection (mode bit above the edge bit)
   typedef enum logic {
      SRC_CYCLE = 1'b0,
      SRC_PIN   = 1'b1
   } cnt_src_e;

   // active pin edge
   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } pin_edge_e;

   // prescaler ownership
   typedef enum logic {
      PSC_TO_CNT = 1'b0,
      PSC_TO_WDT = 1'b1
   } psc_owner_e;

   // number of single-bit flags above the ratio code in the mode word
   localparam int MODE_FLAGS = 3;

   // reset values of the mode word fields
   localparam cnt_src_e   SRC_RST   = SRC_PIN;
   localparam pin_edge_e  EDGE_RST  = EDGE_FALL;
   localparam psc_owner_e OWNER_RST = PSC_TO_WDT;

endpackage

// File: rtl/tmr_evt_src.sv
module tmr_evt_src
   import tmr_wdog_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pin,
   input  cnt_src_e  src_sel,
   input  pin_edge_e edge_sel,
   output logic      src_evt
);

   logic pin_q;
   logic pin_rise;
   logic pin_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= 1'b0;
      else        pin_q <= pin;
   end

   assign pin_rise = pin & ~pin_q;
   assign pin_fall = ~pin & pin_q;

   always_comb begin
      if (src_sel == SRC_PIN)
         src_evt = (edge_sel == EDGE_FALL) ? pin_fall : pin_rise;
      else
         src_evt = 1'b1;
   end

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int RATIO_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               evt,
   input  logic [RATIO_W-1:0] ratio,
   input  logic               extra_stage,
   output logic               out_pulse
);

   localparam int PSC_W = 1 << RATIO_W;
   localparam int TAP_W = RATIO_W + 1;

   logic [PSC_W-1:0] div_q;
   logic [PSC_W-1:0] tap_mask;
   logic [TAP_W-1:0] taps;

   // number of low prescaler bits that must be all ones
   assign taps = TAP_W'(ratio) + TAP_W'(extra_stage);

   for (genvar b = 0; b < PSC_W; b++) begin : g_mask
      assign tap_mask[b] = (taps > TAP_W'(b));
   end

   assign out_pulse = evt & ~clr & ((div_q & tap_mask) == tap_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   div_q <= '0;
      else if (clr) div_q <= '0;
      else if (evt) div_q <= div_q + PSC_W'(1);
   end

endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CNT_W-1:0] wdata,
   input  logic             inc,
   output logic [CNT_W-1:0] value,
   output logic             wrap
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value <= '0;
         wrap  <= 1'b0;
      end else begin
         wrap <= 1'b0;
         if (we) begin
            value <= wdata;
         end else if (inc) begin
            value <= value + CNT_W'(1);
            wrap  <= &value;
         end
      end
   end

endmodule

// File: rtl/tmr_wdog_base.sv
module tmr_wdog_base #(
   parameter int BASE_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic clr,
   input  logic en,
   output logic base_evt
);

   if (BASE_W == 0) begin : g_direct
      // every tick is a full base period
      assign base_evt = tick & en & ~clr;
   end else begin : g_counted
      logic [BASE_W-1:0] base_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           base_q <= '0;
         else if (clr || !en)  base_q <= '0;
         else if (tick)        base_q <= base_q + BASE_W'(1);
      end

      assign base_evt = tick & en & ~clr & (&base_q);
   end

endmodule

// File: rtl/tmr_wdog_unit.sv
module tmr_wdog_unit
   import tmr_wdog_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter int RATIO_W    = 3,
   parameter int WDT_BASE_W = 4,
   localparam int MODE_W    = RATIO_W + MODE_FLAGS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_we,
   input  logic [MODE_W-1:0] mode_wdata,
   input  logic              cnt_we,
   input  logic [CNT_W-1:0]  cnt_wdata,
   output logic [CNT_W-1:0]  cnt_rdata,
   output logic              cnt_ovf,
   input  logic              ext_pin,
   input  logic              wdt_tick,
   input  logic              wdt_clr,
   input  logic              wdt_en,
   output logic              wdt_timeout
);

   localparam int OWNER_BIT = RATIO_W;
   localparam int EDGE_BIT  = RATIO_W + 1;
   localparam int SRC_BIT   = RATIO_W + 2;

   // elaboration-time parameter checks
   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("tmr_wdog_unit: CNT_W must be at least 2");
   end
   if (RATIO_W < 1 || RATIO_W > 5) begin : g_bad_ratio_w
      $error("tmr_wdog_unit: RATIO_W must be 1..5");
   end
   if (WDT_BASE_W < 0 || WDT_BASE_W > 24) begin : g_bad_base_w
      $error("tmr_wdog_unit: WDT_BASE_W must be 0..24");
   end

   // mode word
   logic [RATIO_W-1:0] ratio_q;
   psc_owner_e         owner_q;
   pin_edge_e          edge_q;
   cnt_src_e           src_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ratio_q <= '1;
         owner_q <= OWNER_RST;
         edge_q  <= EDGE_RST;
         src_q   <= SRC_RST;
      end else if (mode_we) begin
         ratio_q <= mode_wdata[RATIO_W-1:0];
         owner_q <= psc_owner_e'(mode_wdata[OWNER_BIT]);
         edge_q  <= pin_edge_e'(mode_wdata[EDGE_BIT]);
         src_q   <= cnt_src_e'(mode_wdata[SRC_BIT]);
      end
   end

   logic psc_wdt;
   logic src_evt;
   logic base_evt;
   logic psc_evt;
   logic psc_clr;
   logic psc_out;
   logic cnt_inc;
   logic wdt_fire;
   logic timeout_q;

   assign psc_wdt = (owner_q == PSC_TO_WDT);

   tmr_evt_src u_src (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (ext_pin),
      .src_sel  (src_q),
      .edge_sel (edge_q),
      .src_evt  (src_evt)
   );

   tmr_wdog_base #(.BASE_W(WDT_BASE_W)) u_base (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (wdt_tick),
      .clr      (wdt_clr),
      .en       (wdt_en),
      .base_evt (base_evt)
   );

   // prescaler routing: its input, clear and output follow the owner
   assign psc_evt = psc_wdt ? base_evt : src_evt;
   assign psc_clr = psc_wdt ? wdt_clr  : cnt_we;

   tmr_prescaler #(.RATIO_W(RATIO_W)) u_psc (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (psc_clr),
      .evt         (psc_evt),
      .ratio       (ratio_q),
      .extra_stage (~psc_wdt),
      .out_pulse   (psc_out)
   );

   assign cnt_inc  = psc_wdt ? src_evt : psc_out;
   assign wdt_fire = psc_wdt ? psc_out : base_evt;

   tmr_count #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cnt_we),
      .wdata (cnt_wdata),
      .inc   (cnt_inc),
      .value (cnt_rdata),
      .wrap  (cnt_ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) timeout_q <= 1'b0;
      else        timeout_q <= wdt_fire;
   end

   assign wdt_timeout = timeout_q;

endmodule

// File: rtl/tmr_wdog_chk.sv
module tmr_wdog_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cnt_we,
   input logic [CNT_W-1:0] cnt_wdata,
   input logic [CNT_W-1:0] cnt_rdata,
   input logic             cnt_ovf,
   input logic             wdt_clr,
   input logic             wdt_en,
   input logic             wdt_timeout,
   input logic             src_pin_q,
   input logic             psc_wdt_q
);

   // R2
   cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_we |=> (cnt_rdata == $past(cnt_wdata)));

   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_we |=> ((cnt_rdata == $past(cnt_rdata)) ||
                   (cnt_rdata == $past(cnt_rdata) + CNT_W'(1))));

   // R3
   direct_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_we && !src_pin_q && psc_wdt_q) |=>
         (cnt_rdata == $past(cnt_rdata) + CNT_W'(1)));

   // R7
   ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_ovf |-> (cnt_rdata == '0));

   // R7
   ovf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_ovf |=> !cnt_ovf);

   // R8
   timeout_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_timeout |=> !wdt_timeout);

   // R10
   wdt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_clr |=> !wdt_timeout);

   // R11
   wdt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wdt_en |=> !wdt_timeout);

endmodule

bind tmr_wdog_unit tmr_wdog_chk #(.CNT_W(CNT_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .cnt_we      (cnt_we),
   .cnt_wdata   (cnt_wdata),
   .cnt_rdata   (cnt_rdata),
   .cnt_ovf     (cnt_ovf),
   .wdt_clr     (wdt_clr),
   .wdt_en      (wdt_en),
   .wdt_timeout (wdt_timeout),
   .src_pin_q   (src_q),
   .psc_wdt_q   (psc_wdt)
);

// File: tb/tmr_wdog_unit_tb_top.sv
`timescale 1ns/1ps
module tmr_wdog_unit_tb_top;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       mode_we;
   logic [5:0] mode_wdata;
   logic       cnt_we;
   logic [7:0] cnt_wdata;
   logic [7:0] cnt_rdata;
   logic       cnt_ovf;
   logic       ext_pin;
   logic       wdt_tick;
   logic       wdt_clr;
   logic       wdt_en;
   logic       wdt_timeout;

   int n_checks = 0;
   int n_errors = 0;
   int to_seen  = 0;

   always #2 clk = ~clk;   // 250 MHz

   tmr_wdog_unit dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_we     (mode_we),
      .mode_wdata  (mode_wdata),
      .cnt_we      (cnt_we),
      .cnt_wdata   (cnt_wdata),
      .cnt_rdata   (cnt_rdata),
      .cnt_ovf     (cnt_ovf),
      .ext_pin     (ext_pin),
      .wdt_tick    (wdt_tick),
      .wdt_clr     (wdt_clr),
      .wdt_en      (wdt_en),
      .wdt_timeout (wdt_timeout)
   );

   // time-out pulse monitor, sampled before each edge updates it
   always @(posedge clk) if (rst_n && wdt_timeout) to_seen++;

   task automatic chk(input string req, input string what,
                      input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_mode(input logic [5:0] v);
      mode_we = 1'b1; mode_wdata = v;
      @(negedge clk);
      mode_we = 1'b0;
   endtask

   task automatic write_cnt(input logic [7:0] v);
      cnt_we = 1'b1; cnt_wdata = v;
      @(negedge clk);
      cnt_we = 1'b0;
   endtask

   task automatic pulse_clr();
      wdt_clr = 1'b1;
      @(negedge clk);
      wdt_clr = 1'b0;
   endtask

   task automatic send_ticks(input int n);
      repeat (n) begin
         wdt_tick = 1'b1;
         @(negedge clk);
         wdt_tick = 1'b0;
         @(negedge clk);
      end
      wait_cyc(2);
   endtask

   task automatic pin_pulse();
      ext_pin = 1'b1; wait_cyc(2);
      ext_pin = 1'b0; wait_cyc(2);
   endtask

   // R1: reset state and idle behaviour with the reset mode
   task automatic t_reset();
      chk("R1", "count in reset", int'(cnt_rdata), 0);
      chk("R1", "ovf in reset", int'(cnt_ovf), 0);
      chk("R1", "timeout in reset", int'(wdt_timeout), 0);
      rst_n = 1'b1;
      wait_cyc(6);
      chk("R1", "count idle after reset", int'(cnt_rdata), 0);
   endtask

   // R2, R3: direct cycle counting and write precedence
   task automatic t_direct();
      write_mode(6'h08);
      write_cnt(8'h10);
      chk("R2", "loaded value", int'(cnt_rdata), 'h10);
      wait_cyc(5);
      chk("R3", "five cycles later", int'(cnt_rdata), 'h15);
      write_cnt(8'hA5);
      chk("R2", "write over increment", int'(cnt_rdata), 'hA5);
   endtask

   // R4: prescaled clock counting at several ratios
   task automatic t_prescaled(input int k);
      int per;
      per = 1 << (k + 1);
      write_mode(6'(k));
      write_cnt(8'h40);
      wait_cyc(per - 1);
      chk("R4", $sformatf("k=%0d before step", k), int'(cnt_rdata), 'h40);
      wait_cyc(1);
      chk("R4", $sformatf("k=%0d first step", k), int'(cnt_rdata), 'h41);
      wait_cyc(per);
      chk("R4", $sformatf("k=%0d second step", k), int'(cnt_rdata), 'h42);
   endtask

   // R5: counter write restarts the prescaler
   task automatic t_psc_clear();
      write_mode(6'h02);
      write_cnt(8'h20);
      wait_cyc(5);
      write_cnt(8'h20);
      wait_cyc(7);
      chk("R5", "no step 7 cycles after rewrite", int'(cnt_rdata), 'h20);
      wait_cyc(1);
      chk("R5", "step 8 cycles after rewrite", int'(cnt_rdata), 'h21);
   endtask

   // R7: wrap and overflow pulse
   task automatic t_wrap();
      write_mode(6'h08);
      write_cnt(8'hFE);
      chk("R7", "ovf low at FE", int'(cnt_ovf), 0);
      wait_cyc(1);
      chk("R7", "count FF", int'(cnt_rdata), 'hFF);
      chk("R7", "ovf low at FF", int'(cnt_ovf), 0);
      wait_cyc(1);
      chk("R7", "count wrapped", int'(cnt_rdata), 0);
      chk("R7", "ovf high at wrap", int'(cnt_ovf), 1);
      wait_cyc(1);
      chk("R7", "count after wrap", int'(cnt_rdata), 1);
      chk("R7", "ovf one cycle", int'(cnt_ovf), 0);
   endtask

   // R6, R4: pin source, edge choice, prescaled pin counting
   task automatic t_pin();
      ext_pin = 1'b0;
      write_mode(6'h28);
      write_cnt(8'h00);
      repeat (3) pin_pulse();
      chk("R6", "rising edges counted", int'(cnt_rdata), 3);
      write_mode(6'h38);
      write_cnt(8'h00);
      ext_pin = 1'b1; wait_cyc(2);
      chk("R6", "rising ignored in falling mode", int'(cnt_rdata), 0);
      ext_pin = 1'b0; wait_cyc(2);
      chk("R6", "falling edge counted", int'(cnt_rdata), 1);
      write_mode(6'h20);
      write_cnt(8'h00);
      repeat (3) pin_pulse();
      chk("R4", "pin 1:2 after 3 edges", int'(cnt_rdata), 1);
      pin_pulse();
      chk("R4", "pin 1:2 after 4 edges", int'(cnt_rdata), 2);
   endtask

   // R8: direct watchdog time-out, both prescaler owners
   task automatic t_wdog_direct(input logic [5:0] mode, input string tag);
      int base;
      write_mode(mode);
      pulse_clr();
      base = to_seen;
      send_ticks(15);
      chk("R8", {tag, " 15 ticks"}, to_seen - base, 0);
      send_ticks(1);
      chk("R8", {tag, " 16 ticks"}, to_seen - base, 1);
      send_ticks(16);
      chk("R8", {tag, " 32 ticks"}, to_seen - base, 2);
   endtask

   // R9, R10: prescaled watchdog and clear of the prescaler
   task automatic t_wdog_ratio();
      int base;
      write_mode(6'h0A);
      pulse_clr();
      send_ticks(40);
      pulse_clr();
      base = to_seen;
      send_ticks(63);
      chk("R10", "prescaler cleared by wdt_clr", to_seen - base, 0);
      send_ticks(1);
      chk("R9", "1:4 time-out at 64 ticks", to_seen - base, 1);
      write_mode(6'h0F);
      pulse_clr();
      base = to_seen;
      send_ticks(2047);
      chk("R9", "1:128 before 2048 ticks", to_seen - base, 0);
      send_ticks(1);
      chk("R9", "1:128 at 2048 ticks", to_seen - base, 1);
   endtask

   // R10: clear wins over a tick in the same cycle
   task automatic t_clr_wins();
      int base;
      write_mode(6'h08);
      pulse_clr();
      base = to_seen;
      send_ticks(15);
      wdt_tick = 1'b1; wdt_clr = 1'b1;
      @(negedge clk);
      wdt_tick = 1'b0; wdt_clr = 1'b0;
      wait_cyc(2);
      chk("R10", "no time-out on clear with tick", to_seen - base, 0);
      send_ticks(15);
      chk("R10", "15 ticks after clear", to_seen - base, 0);
      send_ticks(1);
      chk("R10", "16 ticks after clear", to_seen - base, 1);
   endtask

   // R11: disabled watchdog ignores ticks and holds its count
   task automatic t_wdog_off();
      int base;
      write_mode(6'h08);
      pulse_clr();
      wdt_en = 1'b0;
      base = to_seen;
      send_ticks(24);
      chk("R11", "no time-out while disabled", to_seen - base, 0);
      wdt_en = 1'b1;
      wait_cyc(1);
      send_ticks(15);
      chk("R11", "count held at zero while off", to_seen - base, 0);
      send_ticks(1);
      chk("R11", "full period after enable", to_seen - base, 1);
   endtask

   initial begin
      rst_n = 1'b0; mode_we = 1'b0; mode_wdata = '0;
      cnt_we = 1'b0; cnt_wdata = '0; ext_pin = 1'b0;
      wdt_tick = 1'b0; wdt_clr = 1'b0; wdt_en = 1'b1;
      wait_cyc(3);
      t_reset();
      t_direct();
      t_prescaled(0);
      t_prescaled(2);
      t_prescaled(7);
      t_psc_clear();
      t_wrap();
      t_pin();
      t_wdog_direct(6'h08, "wdt owner k=0");
      t_wdog_direct(6'h00, "counter owner");
      t_wdog_ratio();
      t_clr_wins();
      t_wdog_off();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #(4 * 150000);
      n_checks++;
      n_errors++;
      $display("FAIL run: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule